// File: doc/BRIEF.md
# Controller Command Packet Decoder and Responder

This block sits behind a byte-serial transfer engine. Each inbound packet arrives as a burst of bytes with a final-byte marker. The first byte gives the packet class. Peripheral-bus packets are not handled here: their remaining bytes pass straight out on a side port for a bus controller to consume. Controller-class packets carry a command code in their second byte, and any further bytes are that command's arguments.

For a controller packet, the block first checks that the command is known. It then checks that the number of arguments is right for that command. It performs the command's action and queues a reply packet, which is streamed out one byte per cycle. The block keeps a 32-bit seconds clock counted from the start of 1904. Host software can read and load this clock as four most-significant-first bytes. The block also drives two single-cycle request strobes, one for power-off and one for system reset, and holds a 16-bit device poll mask.

Top module: `cmdpkt_responder`

## Requirements
- R1: After reset, the outputs are in their idle state: no reply byte is valid, the side port is idle, both request strobes are low, and the poll mask is 0xFFFF.
- R2: For a packet whose first byte is 0x00 (peripheral class), every later byte is presented on the side port in arrival order. The final byte of the packet is flagged as last, and no reply is produced.
- R3: No reply and no side-port output is produced for a packet whose first byte is neither 0x00 nor 0x01, or for a 0x01 packet that has no command byte.
- R4: A controller command that is accepted returns the reply 0x01, 0x00, command code, and then any result bytes, with the last byte flagged.
- R5: A command code not in the set {0x01, 0x03, 0x09, 0x0A, 0x11, 0x13, 0x14, 0x19, 0x21} returns the four bytes 0x02, 0x02, 0x01, command.
- R6: A known command with the wrong argument count, including an over-long packet, returns 0x02, 0x05, 0x01, command, and its action is not performed.
- R7: Command 0x03 (read clock) takes no arguments and returns the seconds counter as four bytes, most significant first. After reset the counter holds 2082844800 (0x7C25B080), which is the 1904-based value of 1 January 1970.
- R8: Command 0x09 (load clock) takes exactly four bytes, most significant first, and loads the counter. The counter then advances by one every TICK_DIV clock cycles.
- R9: Command 0x0A (power-off) and command 0x11 (system reset) take no arguments. Each one raises only its own request output, for exactly one cycle.
- R10: Command 0x19 (device list) takes two bytes and sets the poll mask, with the first byte as the upper half. The mask changes at no other time.
- R11: The one-argument commands 0x01, 0x13, 0x21 and 0x14 return the plain accept reply. Command 0x14 with an argument of zero is instead answered with the 0x05 error reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inbound byte valid |
| in_data | input | 8 | Inbound byte |
| in_last | input | 1 | Inbound byte ends the packet |
| fwd_valid | output | 1 | Side-port byte valid (peripheral class) |
| fwd_data | output | 8 | Side-port byte |
| fwd_last | output | 1 | Side-port byte is the packet's last |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_data | output | 8 | Reply byte |
| rsp_last | output | 1 | Reply byte is the reply's last |
| pwr_off_req | output | 1 | One-cycle power-off request |
| sys_rst_req | output | 1 | One-cycle system reset request |
| poll_mask | output | 16 | Device poll mask |

## Verification
The bench builds the block with TICK_DIV = 64 and MAX_LEN = 8. The short tick period lets the bench watch the seconds counter advance several times within a few hundred cycles, while a read taken shortly after a load still returns the loaded value unchanged. The 8-byte capture limit allows a 10-byte packet to overrun the store, which exercises the saturating length path that has to report a wrong argument count.

// File: rtl/cmdpkt_pkg.sv
// Shared codes for the command packet responder: packet classes,
// error reasons and controller command codes.
package cmdpkt_pkg;
    localparam logic [7:0] CLS_PERIPH = 8'h00;
    localparam logic [7:0] CLS_CTRL   = 8'h01;
    localparam logic [7:0] CLS_ERROR  = 8'h02;

    localparam logic [7:0] ERR_UNKNOWN = 8'h02;
    localparam logic [7:0] ERR_BADARG  = 8'h05;

    localparam logic [7:0] CMD_AUTOPOLL = 8'h01;
    localparam logic [7:0] CMD_GETTIME  = 8'h03;
    localparam logic [7:0] CMD_SETTIME  = 8'h09;
    localparam logic [7:0] CMD_PWROFF   = 8'h0A;
    localparam logic [7:0] CMD_SYSRST   = 8'h11;
    localparam logic [7:0] CMD_FILESRV  = 8'h13;
    localparam logic [7:0] CMD_AUTORATE = 8'h14;
    localparam logic [7:0] CMD_DEVLIST  = 8'h19;
    localparam logic [7:0] CMD_PWRMSG   = 8'h21;

    // reply store depth (longest reply is 7 bytes)
    localparam int RPL_DEPTH = 8;
    localparam int RPL_IW    = $clog2(RPL_DEPTH);
endpackage

// File: rtl/cmdpkt_collect.sv
// Packet collector: stores up to MAX_LEN inbound bytes and pulses
// pkt_done for one cycle after the last byte. The length saturates at
// MAX_LEN+1 to flag an overrun. Peripheral-class bytes after the class
// byte are passed through combinationally on the side port.
// Assumes that no new packet starts while a reply is still streaming.
module cmdpkt_collect
    import cmdpkt_pkg::*;
#(
    parameter int MAX_LEN = 8,
    localparam int LEN_W = $clog2(MAX_LEN + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [7:0]                in_data,
    input  logic                      in_last,
    output logic                      pkt_done,
    output logic [MAX_LEN-1:0][7:0]   pkt_bytes,
    output logic [LEN_W-1:0]          pkt_len,
    output logic                      fwd_valid,
    output logic [7:0]                fwd_data,
    output logic                      fwd_last
);
    localparam logic [LEN_W-1:0] CNT_SAT = LEN_W'(MAX_LEN + 1);

    logic [LEN_W-1:0]        cnt;
    logic [LEN_W-1:0]        cnt_nxt;
    logic [7:0]              cls_q;
    logic [MAX_LEN-1:0][7:0] bytes_q;
    logic [LEN_W-1:0]        len_q;
    logic                    done_q;

    // saturating byte position
    assign cnt_nxt = (cnt == CNT_SAT) ? CNT_SAT : cnt + LEN_W'(1);

    // capture bytes, class and final length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            cls_q   <= '0;
            bytes_q <= '0;
            len_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (in_valid) begin
                for (int i = 0; i < MAX_LEN; i++) begin
                    if (cnt == LEN_W'(i)) bytes_q[i] <= in_data;
                end
                if (cnt == '0) cls_q <= in_data;
                if (in_last) begin
                    done_q <= 1'b1;
                    len_q  <= cnt_nxt;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt_nxt;
                end
            end
        end
    end

    // side-port pass-through for peripheral-class payload
    assign fwd_valid = in_valid && (cnt != '0) && (cls_q == CLS_PERIPH);
    assign fwd_data  = in_data;
    assign fwd_last  = fwd_valid && in_last;

    assign pkt_done  = done_q;
    assign pkt_bytes = bytes_q;
    assign pkt_len   = len_q;
endmodule

// File: rtl/cmdpkt_secclk.sv
// Seconds counter: advances once every TICK_DIV clock cycles and
// restarts its prescaler when loaded. Resets to INIT_SEC.
module cmdpkt_secclk #(
    parameter int          TICK_DIV = 100_000_000,
    parameter logic [31:0] INIT_SEC = 32'd2082844800,
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_en,
    input  logic [31:0] ld_val,
    output logic [31:0] seconds
);
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre;

    // prescaler and seconds update, load has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre     <= '0;
            seconds <= INIT_SEC;
        end else if (ld_en) begin
            pre     <= '0;
            seconds <= ld_val;
        end else if (pre == PRE_TOP) begin
            pre     <= '0;
            seconds <= seconds + 32'd1;
        end else begin
            pre <= pre + PRE_W'(1);
        end
    end

    // R8
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ld_en) |-> (seconds == $past(seconds) || seconds == $past(seconds) + 32'd1));
endmodule

// File: rtl/cmdpkt_reply.sv
// Reply unit: decodes a completed controller packet, checks the argument
// count, performs the action and streams the reply one byte per cycle.
// Assumes MAX_LEN >= 6, so that all four clock-load bytes are stored.
module cmdpkt_reply
    import cmdpkt_pkg::*;
#(
    parameter int MAX_LEN = 8,
    localparam int LEN_W = $clog2(MAX_LEN + 2)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pkt_done,
    input  logic [MAX_LEN-1:0][7:0] pkt_bytes,
    input  logic [LEN_W-1:0]        pkt_len,
    input  logic [31:0]             seconds,
    output logic                    ld_en,
    output logic [31:0]             ld_val,
    output logic                    pwr_off_req,
    output logic                    sys_rst_req,
    output logic [15:0]             poll_mask,
    output logic                    rsp_valid,
    output logic [7:0]              rsp_data,
    output logic                    rsp_last
);
    logic [7:0]                  cmd;
    logic [LEN_W-1:0]            nargs;
    logic [LEN_W-1:0]            need;
    logic                        known;
    logic                        zero_bad;
    logic                        args_ok;
    logic                        accept;
    logic [RPL_DEPTH-1:0][7:0]   nb;
    logic [RPL_IW-1:0]           nlen;
    logic [RPL_DEPTH-1:0][7:0]   rbuf;
    logic [RPL_IW-1:0]           rlen;
    logic [RPL_IW-1:0]           idx;
    logic                        busy;

    assign cmd    = pkt_bytes[1];
    assign nargs  = pkt_len - LEN_W'(2);
    assign accept = pkt_done && !busy && (pkt_bytes[0] == CLS_CTRL) && (pkt_len >= LEN_W'(2));

    // command lookup: argument count expected per command
    always_comb begin
        known    = 1'b1;
        need     = '0;
        zero_bad = 1'b0;
        case (cmd)
            CMD_AUTOPOLL, CMD_FILESRV, CMD_PWRMSG: need = LEN_W'(1);
            CMD_AUTORATE: begin
                need     = LEN_W'(1);
                zero_bad = (pkt_bytes[2] == 8'h00);
            end
            CMD_DEVLIST: need = LEN_W'(2);
            CMD_SETTIME: need = LEN_W'(4);
            CMD_GETTIME, CMD_PWROFF, CMD_SYSRST: need = '0;
            default: known = 1'b0;
        endcase
        args_ok = known && (nargs == need) && !zero_bad;
    end

    // reply image: error form by default, accept form when args fit
    always_comb begin
        nb    = '0;
        nb[0] = CLS_ERROR;
        nb[1] = known ? ERR_BADARG : ERR_UNKNOWN;
        nb[2] = CLS_CTRL;
        nb[3] = cmd;
        nlen  = RPL_IW'(4);
        if (args_ok) begin
            nb[0] = CLS_CTRL;
            nb[1] = 8'h00;
            nb[2] = cmd;
            nb[3] = 8'h00;
            nlen  = RPL_IW'(3);
            if (cmd == CMD_GETTIME) begin
                nb[3] = seconds[31:24];
                nb[4] = seconds[23:16];
                nb[5] = seconds[15:8];
                nb[6] = seconds[7:0];
                nlen  = RPL_IW'(7);
            end
        end
    end

    // latch reply, fire actions, and step the reply stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            idx         <= '0;
            rlen        <= '0;
            rbuf        <= '0;
            ld_en       <= 1'b0;
            ld_val      <= '0;
            pwr_off_req <= 1'b0;
            sys_rst_req <= 1'b0;
            poll_mask   <= 16'hFFFF;
        end else begin
            ld_en       <= 1'b0;
            pwr_off_req <= 1'b0;
            sys_rst_req <= 1'b0;
            if (accept) begin
                rbuf <= nb;
                rlen <= nlen;
                idx  <= '0;
                busy <= 1'b1;
                if (args_ok) begin
                    case (cmd)
                        CMD_PWROFF: pwr_off_req <= 1'b1;
                        CMD_SYSRST: sys_rst_req <= 1'b1;
                        CMD_SETTIME: begin
                            ld_en  <= 1'b1;
                            ld_val <= {pkt_bytes[2], pkt_bytes[3], pkt_bytes[4], pkt_bytes[5]};
                        end
                        CMD_DEVLIST: poll_mask <= {pkt_bytes[2], pkt_bytes[3]};
                        default: ;
                    endcase
                end
            end else if (busy) begin
                if (idx == rlen - RPL_IW'(1)) busy <= 1'b0;
                else idx <= idx + RPL_IW'(1);
            end
        end
    end

    assign rsp_valid = busy;
    assign rsp_data  = rbuf[idx];
    assign rsp_last  = busy && (idx == rlen - RPL_IW'(1));

    // R9
    pwr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_req |=> !pwr_off_req);
    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);
    // R9
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_off_req && sys_rst_req));
    // R4
    rsp_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> (rsp_data == CLS_CTRL || rsp_data == CLS_ERROR));
    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pkt_done) |-> $stable(poll_mask));
endmodule

// File: rtl/cmdpkt_responder.sv
// Top level: collector feeds the reply unit, which loads the seconds
// clock. Peripheral-class payload leaves on the side port.
module cmdpkt_responder #(
    parameter int          MAX_LEN  = 8,
    parameter int          TICK_DIV = 100_000_000,
    parameter logic [31:0] INIT_SEC = 32'd2082844800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        fwd_valid,
    output logic [7:0]  fwd_data,
    output logic        fwd_last,
    output logic        rsp_valid,
    output logic [7:0]  rsp_data,
    output logic        rsp_last,
    output logic        pwr_off_req,
    output logic        sys_rst_req,
    output logic [15:0] poll_mask
);
    localparam int LEN_W = $clog2(MAX_LEN + 2);

    logic                    pkt_done;
    logic [MAX_LEN-1:0][7:0] pkt_bytes;
    logic [LEN_W-1:0]        pkt_len;
    logic                    ld_en;
    logic [31:0]             ld_val;
    logic [31:0]             seconds;

    cmdpkt_collect #(.MAX_LEN(MAX_LEN)) u_collect (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .pkt_done(pkt_done), .pkt_bytes(pkt_bytes), .pkt_len(pkt_len),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_last(fwd_last)
    );

    cmdpkt_secclk #(.TICK_DIV(TICK_DIV), .INIT_SEC(INIT_SEC)) u_secclk (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_val(ld_val), .seconds(seconds)
    );

    cmdpkt_reply #(.MAX_LEN(MAX_LEN)) u_reply (
        .clk(clk), .rst_n(rst_n),
        .pkt_done(pkt_done), .pkt_bytes(pkt_bytes), .pkt_len(pkt_len),
        .seconds(seconds), .ld_en(ld_en), .ld_val(ld_val),
        .pwr_off_req(pwr_off_req), .sys_rst_req(sys_rst_req),
        .poll_mask(poll_mask),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
    );
endmodule

// File: tb/cmdpkt_responder_test.sv
`timescale 1ns/1ps
module cmdpkt_responder_test;
    typedef byte unsigned bq_t[$];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        fwd_valid, fwd_last, rsp_valid, rsp_last;
    logic [7:0]  fwd_data, rsp_data;
    logic        pwr_off_req, sys_rst_req;
    logic [15:0] poll_mask;

    int nchk = 0;
    int nbad = 0;
    bq_t rq;
    bq_t fq;
    int  rlast_cnt = 0;
    int  rlast_at  = 0;
    int  flast_cnt = 0;
    int  pwr_cnt   = 0;
    int  rst_cnt   = 0;

    always #2.5 clk = ~clk;

    cmdpkt_responder #(.MAX_LEN(8), .TICK_DIV(64)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_last(fwd_last),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .pwr_off_req(pwr_off_req), .sys_rst_req(sys_rst_req),
        .poll_mask(poll_mask)
    );

    // output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                rq.push_back(rsp_data);
                if (rsp_last) begin
                    rlast_cnt++;
                    rlast_at = rq.size();
                end
            end
            if (fwd_valid) begin
                fq.push_back(fwd_data);
                if (fwd_last) flast_cnt++;
            end
            if (pwr_off_req) pwr_cnt++;
            if (sys_rst_req) rst_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input bq_t tx);
        rq.delete(); fq.delete();
        rlast_cnt = 0; rlast_at = 0; flast_cnt = 0; pwr_cnt = 0; rst_cnt = 0;
        foreach (tx[i]) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = tx[i];
            in_last  = (i == tx.size() - 1);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (16) @(posedge clk);
        #1;
    endtask

    task automatic expect_reply(input string tag, input bq_t exp);
        chk(rq.size() == exp.size(), {tag, " reply length"}, rq.size(), exp.size());
        if (rq.size() == exp.size()) begin
            foreach (exp[i]) chk(rq[i] == exp[i], $sformatf("%s byte %0d", tag, i), rq[i], exp[i]);
        end
        chk(rlast_cnt == (exp.size() != 0 ? 1 : 0) && rlast_at == exp.size(),
            {tag, " last flag"}, rlast_at, exp.size());
    endtask

    function automatic longint rd_time();
        if (rq.size() != 7) return -1;
        return {rq[3], rq[4], rq[5], rq[6]};
    endfunction

    task automatic t_reset();
        chk(!rsp_valid && !fwd_valid, "R1 outputs idle", {rsp_valid, fwd_valid}, 0);
        chk(!pwr_off_req && !sys_rst_req, "R1 strobes low", {pwr_off_req, sys_rst_req}, 0);
        chk(poll_mask == 16'hFFFF, "R1 poll mask", poll_mask, 16'hFFFF);
    endtask

    task automatic t_time();
        run('{8'h01, 8'h03});
        expect_reply("R7 read clock at reset", '{8'h01, 8'h00, 8'h03, 8'h7C, 8'h25, 8'hB0, 8'h80});
        run('{8'h01, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78});
        expect_reply("R8 load clock reply", '{8'h01, 8'h00, 8'h09});
        run('{8'h01, 8'h03});
        expect_reply("R8 read after load", '{8'h01, 8'h00, 8'h03, 8'h12, 8'h34, 8'h56, 8'h78});
        repeat (320) @(posedge clk);
        run('{8'h01, 8'h03});
        chk(rd_time() >= 64'h12345678 + 5 && rd_time() <= 64'h12345678 + 6,
            "R8 clock advance", rd_time(), 64'h12345678 + 5);
    endtask

    task automatic t_unknown();
        run('{8'h01, 8'h55, 8'h09});
        expect_reply("R5 unknown 0x55", '{8'h02, 8'h02, 8'h01, 8'h55});
        run('{8'h01, 8'h00});
        expect_reply("R5 unknown 0x00", '{8'h02, 8'h02, 8'h01, 8'h00});
    endtask

    task automatic t_badargs();
        run('{8'h01, 8'h0A, 8'h00});
        expect_reply("R6 power-off extra arg", '{8'h02, 8'h05, 8'h01, 8'h0A});
        chk(pwr_cnt == 0, "R6 no power-off pulse", pwr_cnt, 0);
        run('{8'h01, 8'h19, 8'hAB});
        expect_reply("R6 device list short", '{8'h02, 8'h05, 8'h01, 8'h19});
        chk(poll_mask == 16'hFFFF, "R6 mask unchanged", poll_mask, 16'hFFFF);
        run('{8'h01, 8'h09, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08});
        expect_reply("R6 over-long load", '{8'h02, 8'h05, 8'h01, 8'h09});
        run('{8'h01, 8'h03});
        chk(rd_time() >= 64'h12345678 && rd_time() < 64'h12345678 + 16,
            "R6 clock not loaded", rd_time(), 64'h12345678);
    endtask

    task automatic t_power();
        run('{8'h01, 8'h0A});
        expect_reply("R9 power-off", '{8'h01, 8'h00, 8'h0A});
        chk(pwr_cnt == 1 && rst_cnt == 0, "R9 power-off strobe", {pwr_cnt, rst_cnt}, 64'h1_00000000);
        run('{8'h01, 8'h11});
        expect_reply("R9 system reset", '{8'h01, 8'h00, 8'h11});
        chk(rst_cnt == 1 && pwr_cnt == 0, "R9 reset strobe", {rst_cnt, pwr_cnt}, 64'h1_00000000);
    endtask

    task automatic t_devlist();
        run('{8'h01, 8'h19, 8'hA5, 8'h3C});
        expect_reply("R10 device list", '{8'h01, 8'h00, 8'h19});
        chk(poll_mask == 16'hA53C, "R10 mask order", poll_mask, 16'hA53C);
    endtask

    task automatic t_onearg();
        run('{8'h01, 8'h01, 8'h01});
        expect_reply("R11 autopoll", '{8'h01, 8'h00, 8'h01});
        run('{8'h01, 8'h13, 8'h00});
        expect_reply("R11 file server", '{8'h01, 8'h00, 8'h13});
        run('{8'h01, 8'h21, 8'h07});
        expect_reply("R11 power message", '{8'h01, 8'h00, 8'h21});
        run('{8'h01, 8'h14, 8'h20});
        expect_reply("R11 rate nonzero", '{8'h01, 8'h00, 8'h14});
        run('{8'h01, 8'h14, 8'h00});
        expect_reply("R11 rate zero", '{8'h02, 8'h05, 8'h01, 8'h14});
        run('{8'h01, 8'h21});
        expect_reply("R11 power message no arg", '{8'h02, 8'h05, 8'h01, 8'h21});
    endtask

    task automatic t_periph();
        run('{8'h00, 8'hAA, 8'hBB, 8'hCC});
        chk(fq.size() == 3, "R2 side byte count", fq.size(), 3);
        if (fq.size() == 3)
            chk(fq[0] == 8'hAA && fq[1] == 8'hBB && fq[2] == 8'hCC,
                "R2 side byte order", {fq[0], fq[1], fq[2]}, 24'hAABBCC);
        chk(flast_cnt == 1, "R2 side last flag", flast_cnt, 1);
        chk(rq.size() == 0, "R2 no reply", rq.size(), 0);
    endtask

    task automatic t_other();
        run('{8'h03, 8'h09, 8'h01, 8'h02, 8'h03, 8'h04});
        chk(rq.size() == 0 && fq.size() == 0, "R3 class 3 ignored", rq.size() + fq.size(), 0);
        run('{8'h06, 8'h0A});
        chk(rq.size() == 0 && pwr_cnt == 0, "R3 class 6 ignored", rq.size() + pwr_cnt, 0);
        run('{8'h01});
        chk(rq.size() == 0 && fq.size() == 0, "R3 bare controller byte", rq.size() + fq.size(), 0);
        run('{8'h01, 8'h03});
        chk(rq.size() == 7 && rd_time() < 64'h12345678 + 16, "R3 clock untouched", rd_time(), 64'h12345678);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_time();
        t_unknown();
        t_badargs();
        t_power();
        t_devlist();
        t_onearg();
        t_periph();
        t_other();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
        summary();
        $finish;
    end
endmodule